// File: doc/BRIEF.md
# Response Validation Tag Tracker

This block sits beside a requester that issues non-posted requests. Each request it issues is recorded in a table indexed by source tag. The table keeps the request class (sized read, atomic read-modify-write or non-posted write) and, for the classes that return data, the data count that was asked for. Responses reach the block already matched to the requester's own unit ID. For each one the block checks that the tag is outstanding, that the response kind fits the request class, and that a read response carries the count that was requested. A response that passes retires its tag. A response that fails raises a response error with a cause code, leaves the table untouched, sets a sticky log bit, and can raise a fatal or a non-fatal interrupt request, depending on two enable inputs.

When the chain goes down, the block stops accepting requests and responses. It then issues one error completion for every outstanding tag, lowest tag first, one per cycle, on a valid/ready interface. When the last completion is taken, the table is empty and normal operation resumes.

Top module: `resp_tag_tracker`

## Requirements
- R1: A request whose tag is free marks that tag busy in `busy_vec` after the clock edge and stores its class and count. A request to a tag that is already busy is ignored, and the original entry stays in force.
- R2: A response that fits its outstanding entry pulses `rsp_done` for one cycle, one clock after it is presented, and frees the tag. A read response (`rsp_is_read`=1) fits a sized read (class 2'b00) or an atomic (class 2'b01) when its count is equal to the stored count. A target-done response (`rsp_is_read`=0) fits a non-posted write (class 2'b10) or class 2'b11.
- R3: A response to a tag that is not busy pulses `rsp_err` with `rsp_err_code` 2'd0.
- R4: A read response to a tag that expects target-done pulses `rsp_err` with code 2'd1.
- R5: A target-done response to a sized read or an atomic pulses `rsp_err` with code 2'd2.
- R6: A read response to a sized read or an atomic whose count differs from the stored count pulses `rsp_err` with code 2'd3. Every erroneous response leaves the table unchanged.
- R7: Every response error sets `err_log`, which stays set until reset. In the same cycle as `rsp_err`, the error also pulses `irq_fatal` when `cfg_fatal_en` is set and `irq_nonfatal` when `cfg_nonfatal_en` is set.
- R8: A `chain_fail` pulse starts a flush. From the next cycle on, `flush_valid` presents the lowest busy tag with its class. The tag is held while `flush_ready` is low, each handshake frees that tag, and the flush ends when no tag is left busy. Requests and responses that arrive in the cycle of `chain_fail`, or during the flush, are ignored.
- R9: After reset, every tag is free and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A non-posted request is being issued |
| req_tag | input | TAG_W | Source tag of the request |
| req_kind | input | 2 | Request class: 00 sized read, 01 atomic, 10 non-posted write |
| req_count | input | CNT_W | Requested data count |
| rsp_valid | input | 1 | A response addressed to this requester is present |
| rsp_tag | input | TAG_W | Source tag carried by the response |
| rsp_is_read | input | 1 | 1 read response, 0 target-done |
| rsp_count | input | CNT_W | Data count carried by a read response |
| cfg_fatal_en | input | 1 | Map response errors to a fatal interrupt request |
| cfg_nonfatal_en | input | 1 | Map response errors to a non-fatal interrupt request |
| chain_fail | input | 1 | Chain-down event, one-cycle pulse |
| flush_ready | input | 1 | Consumer accepts the current error completion |
| busy_vec | output | NUM_TAGS | Outstanding state of every tag |
| rsp_done | output | 1 | Response retired its tag |
| rsp_err | output | 1 | Response error |
| rsp_err_code | output | 2 | Cause of the last response error |
| err_log | output | 1 | Sticky response-error log |
| irq_fatal | output | 1 | Fatal interrupt request pulse |
| irq_nonfatal | output | 1 | Non-fatal interrupt request pulse |
| flush_valid | output | 1 | An error completion is offered |
| flush_tag | output | TAG_W | Tag of the offered completion |
| flush_kind | output | 2 | Class of the flushed request |

## Verification
The bench goes after the tags at both ends of the range, a response that repeats after its tag is already retired, and a count that is off by one on an atomic. A design that checked the count on target-done, or that freed a tag on an erroneous response, would fail the retry that follows each error. It also issues a second request to a tag that is already busy; a design that overwrote the entry would answer the later response with the wrong kind. During a flush, it holds `flush_ready` low and slips a response and a request into the chain-fail cycle and into the flush itself. A design that skipped tags, moved the offered tag under back-pressure, or let traffic through during the flush would show a wrong tag, a stray pulse, or a busy bit left over afterwards.

// File: rtl/resp_trk_pkg.sv
package resp_trk_pkg;

   typedef enum logic [1:0] {
      KIND_RDSZ = 2'b00,
      KIND_ATOM = 2'b01,
      KIND_NPWR = 2'b10,
      KIND_RSVD = 2'b11
   } req_kind_e;

   typedef enum logic [1:0] {
      ERR_NOTAG       = 2'd0,
      ERR_RD_FOR_WR   = 2'd1,
      ERR_DONE_FOR_RD = 2'd2,
      ERR_COUNT       = 2'd3
   } rsp_err_e;

   // Classes that are answered by a read response carrying data.
   function automatic logic expects_data(input logic [1:0] kind);
      return (kind == KIND_RDSZ) || (kind == KIND_ATOM);
   endfunction

endpackage

// File: rtl/rtt_tag_table.sv
module rtt_tag_table #(
   parameter int NUM_TAGS = 32,
   parameter int TAG_W    = $clog2(NUM_TAGS),
   parameter int CNT_W    = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                alloc_en,
   input  logic [TAG_W-1:0]    alloc_tag,
   input  logic [1:0]          alloc_kind,
   input  logic [CNT_W-1:0]    alloc_cnt,
   input  logic                retire_en,
   input  logic [TAG_W-1:0]    retire_tag,
   input  logic                flush_clr_en,
   input  logic [TAG_W-1:0]    flush_clr_tag,
   input  logic [TAG_W-1:0]    lookup_tag,
   output logic [NUM_TAGS-1:0] busy_vec,
   output logic                lk_busy,
   output logic [1:0]          lk_kind,
   output logic [CNT_W-1:0]    lk_cnt,
   output logic [1:0]          fl_kind
);

   logic [1:0]       kind_q [NUM_TAGS];
   logic [CNT_W-1:0] cnt_q  [NUM_TAGS];

   for (genvar t = 0; t < NUM_TAGS; t++) begin : g_entry
      logic set_t, clr_t;
      assign set_t = alloc_en && (alloc_tag == TAG_W'(t));
      assign clr_t = (retire_en && (retire_tag == TAG_W'(t))) ||
                     (flush_clr_en && (flush_clr_tag == TAG_W'(t)));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            busy_vec[t] <= 1'b0;
            kind_q[t]   <= '0;
            cnt_q[t]    <= '0;
         end else if (set_t) begin
            busy_vec[t] <= 1'b1;
            kind_q[t]   <= alloc_kind;
            cnt_q[t]    <= alloc_cnt;
         end else if (clr_t) begin
            busy_vec[t] <= 1'b0;
         end
      end
   end

   assign lk_busy = busy_vec[lookup_tag];
   assign lk_kind = kind_q[lookup_tag];
   assign lk_cnt  = cnt_q[lookup_tag];
   assign fl_kind = kind_q[flush_clr_tag];

endmodule

// File: rtl/rtt_rsp_check.sv
module rtt_rsp_check
   import resp_trk_pkg::*;
#(
   parameter int CNT_W = 4
) (
   input  logic             is_read,
   input  logic [CNT_W-1:0] rsp_cnt,
   input  logic             lk_busy,
   input  logic [1:0]       lk_kind,
   input  logic [CNT_W-1:0] lk_cnt,
   output logic             ok,
   output logic             err,
   output logic [1:0]       code
);

   always_comb begin
      ok   = 1'b0;
      err  = 1'b0;
      code = ERR_NOTAG;
      if (!lk_busy) begin
         err  = 1'b1;
         code = ERR_NOTAG;
      end else if (expects_data(lk_kind)) begin
         if (!is_read) begin
            err  = 1'b1;
            code = ERR_DONE_FOR_RD;
         end else if (rsp_cnt != lk_cnt) begin
            err  = 1'b1;
            code = ERR_COUNT;
         end else begin
            ok = 1'b1;
         end
      end else if (is_read) begin
         err  = 1'b1;
         code = ERR_RD_FOR_WR;
      end else begin
         ok = 1'b1;
      end
   end

endmodule

// File: rtl/rtt_flush_seq.sv
module rtt_flush_seq #(
   parameter int NUM_TAGS = 32,
   parameter int TAG_W    = $clog2(NUM_TAGS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [NUM_TAGS-1:0] busy_vec,
   input  logic                ready,
   output logic                active,
   output logic                valid,
   output logic [TAG_W-1:0]    tag,
   output logic                clr_en
);

   logic                found;
   logic [NUM_TAGS-1:0] clr_mask;
   logic [NUM_TAGS-1:0] remaining;

   // Lowest busy tag wins: scan downward so the last hit is the smallest.
   always_comb begin
      found = 1'b0;
      tag   = '0;
      for (int i = NUM_TAGS - 1; i >= 0; i--) begin
         if (busy_vec[i]) begin
            found = 1'b1;
            tag   = TAG_W'(i);
         end
      end
   end

   assign valid     = active && found;
   assign clr_en    = valid && ready;
   assign clr_mask  = clr_en ? (NUM_TAGS'(1) << tag) : '0;
   assign remaining = busy_vec & ~clr_mask;

   always_ff @(posedge clk) begin
      if (!rst_n)
         active <= 1'b0;
      else if (start)
         active <= 1'b1;
      else if (active && (remaining == '0))
         active <= 1'b0;
   end

endmodule

// File: rtl/resp_tag_tracker.sv
module resp_tag_tracker
   import resp_trk_pkg::*;
#(
   parameter int NUM_TAGS = 32,
   parameter int TAG_W    = $clog2(NUM_TAGS),
   parameter int CNT_W    = 4,
   parameter bit REG_IRQ  = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic [TAG_W-1:0]    req_tag,
   input  logic [1:0]          req_kind,
   input  logic [CNT_W-1:0]    req_count,
   input  logic                rsp_valid,
   input  logic [TAG_W-1:0]    rsp_tag,
   input  logic                rsp_is_read,
   input  logic [CNT_W-1:0]    rsp_count,
   input  logic                cfg_fatal_en,
   input  logic                cfg_nonfatal_en,
   input  logic                chain_fail,
   input  logic                flush_ready,
   output logic [NUM_TAGS-1:0] busy_vec,
   output logic                rsp_done,
   output logic                rsp_err,
   output logic [1:0]          rsp_err_code,
   output logic                err_log,
   output logic                irq_fatal,
   output logic                irq_nonfatal,
   output logic                flush_valid,
   output logic [TAG_W-1:0]    flush_tag,
   output logic [1:0]          flush_kind
);

   if (NUM_TAGS < 2) begin : g_bad_tags
      $error("resp_tag_tracker: NUM_TAGS must be at least 2");
   end
   if ((1 << TAG_W) < NUM_TAGS) begin : g_bad_tagw
      $error("resp_tag_tracker: TAG_W too narrow for NUM_TAGS");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("resp_tag_tracker: CNT_W must be at least 1");
   end

   logic             fl_active, fl_clr_en;
   logic             quiet;
   logic             alloc_en, rsp_take, retire_en;
   logic             lk_busy;
   logic [1:0]       lk_kind;
   logic [CNT_W-1:0] lk_cnt;
   logic             chk_ok, chk_err;
   logic [1:0]       chk_code;

   // Traffic is frozen in the chain-fail cycle and for the whole flush.
   assign quiet     = chain_fail || fl_active;
   assign alloc_en  = req_valid && !quiet && !busy_vec[req_tag];
   assign rsp_take  = rsp_valid && !quiet;
   assign retire_en = rsp_take && chk_ok;

   rtt_tag_table #(.NUM_TAGS(NUM_TAGS), .TAG_W(TAG_W), .CNT_W(CNT_W)) u_table (
      .clk          (clk),
      .rst_n        (rst_n),
      .alloc_en     (alloc_en),
      .alloc_tag    (req_tag),
      .alloc_kind   (req_kind),
      .alloc_cnt    (req_count),
      .retire_en    (retire_en),
      .retire_tag   (rsp_tag),
      .flush_clr_en (fl_clr_en),
      .flush_clr_tag(flush_tag),
      .lookup_tag   (rsp_tag),
      .busy_vec     (busy_vec),
      .lk_busy      (lk_busy),
      .lk_kind      (lk_kind),
      .lk_cnt       (lk_cnt),
      .fl_kind      (flush_kind)
   );

   rtt_rsp_check #(.CNT_W(CNT_W)) u_check (
      .is_read(rsp_is_read),
      .rsp_cnt(rsp_count),
      .lk_busy(lk_busy),
      .lk_kind(lk_kind),
      .lk_cnt (lk_cnt),
      .ok     (chk_ok),
      .err    (chk_err),
      .code   (chk_code)
   );

   rtt_flush_seq #(.NUM_TAGS(NUM_TAGS), .TAG_W(TAG_W)) u_flush (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (chain_fail),
      .busy_vec(busy_vec),
      .ready   (flush_ready),
      .active  (fl_active),
      .valid   (flush_valid),
      .tag     (flush_tag),
      .clr_en  (fl_clr_en)
   );

   logic err_now;
   assign err_now = rsp_take && chk_err;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_done     <= 1'b0;
         rsp_err      <= 1'b0;
         rsp_err_code <= '0;
         err_log      <= 1'b0;
      end else begin
         rsp_done <= retire_en;
         rsp_err  <= err_now;
         if (err_now) begin
            rsp_err_code <= chk_code;
            err_log      <= 1'b1;
         end
      end
   end

   if (REG_IRQ) begin : g_irq_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            irq_fatal    <= 1'b0;
            irq_nonfatal <= 1'b0;
         end else begin
            irq_fatal    <= err_now && cfg_fatal_en;
            irq_nonfatal <= err_now && cfg_nonfatal_en;
         end
      end
   end else begin : g_irq_comb
      // Derived from the registered error pulse, so timing matches rsp_err.
      logic fat_en_q, nf_en_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            fat_en_q <= 1'b0;
            nf_en_q  <= 1'b0;
         end else begin
            fat_en_q <= cfg_fatal_en;
            nf_en_q  <= cfg_nonfatal_en;
         end
      end
      assign irq_fatal    = rsp_err && fat_en_q;
      assign irq_nonfatal = rsp_err && nf_en_q;
   end

endmodule

// File: rtl/rtt_checker.sv
module rtt_checker #(
   parameter int NUM_TAGS = 32,
   parameter int TAG_W    = $clog2(NUM_TAGS)
) (
   input logic                clk,
   input logic                rst_n,
   input logic                flush_valid,
   input logic                flush_ready,
   input logic [TAG_W-1:0]    flush_tag,
   input logic [NUM_TAGS-1:0] busy_vec,
   input logic                rsp_done,
   input logic                rsp_err,
   input logic                err_log,
   input logic                irq_fatal,
   input logic                irq_nonfatal
);

   a_r2_done_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(rsp_done && rsp_err));

   a_r7_log_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      err_log |=> err_log);

   a_r7_err_logged: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> err_log);

   a_r7_irq_needs_err: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_fatal || irq_nonfatal) |-> rsp_err);

   a_r8_flush_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_valid && !flush_ready) |=> (flush_valid && $stable(flush_tag)));

   a_r8_flush_frees: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_valid && flush_ready) |=> !busy_vec[$past(flush_tag)]);

   a_r8_flush_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      flush_valid |-> (!rsp_done && !rsp_err));

   a_r8_offer_busy: assert property (@(posedge clk) disable iff (!rst_n)
      flush_valid |-> busy_vec[flush_tag]);

endmodule

bind resp_tag_tracker rtt_checker #(.NUM_TAGS(NUM_TAGS), .TAG_W(TAG_W)) u_rtt_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .flush_valid (flush_valid),
   .flush_ready (flush_ready),
   .flush_tag   (flush_tag),
   .busy_vec    (busy_vec),
   .rsp_done    (rsp_done),
   .rsp_err     (rsp_err),
   .err_log     (err_log),
   .irq_fatal   (irq_fatal),
   .irq_nonfatal(irq_nonfatal)
);

// File: tb/resp_tag_tracker_test.sv
module resp_tag_tracker_test;

   localparam int NT = 32;
   localparam int TW = 5;
   localparam int CW = 4;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          req_valid, rsp_valid, rsp_is_read;
   logic [TW-1:0] req_tag, rsp_tag;
   logic [1:0]    req_kind;
   logic [CW-1:0] req_count, rsp_count;
   logic          cfg_fatal_en, cfg_nonfatal_en, chain_fail, flush_ready;
   logic [NT-1:0] busy_vec;
   logic          rsp_done, rsp_err, err_log, irq_fatal, irq_nonfatal;
   logic [1:0]    rsp_err_code, flush_kind;
   logic          flush_valid;
   logic [TW-1:0] flush_tag;

   int n_chk  = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   resp_tag_tracker #(.NUM_TAGS(NT), .TAG_W(TW), .CNT_W(CW)) uut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_tag(req_tag), .req_kind(req_kind), .req_count(req_count),
      .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_is_read(rsp_is_read), .rsp_count(rsp_count),
      .cfg_fatal_en(cfg_fatal_en), .cfg_nonfatal_en(cfg_nonfatal_en),
      .chain_fail(chain_fail), .flush_ready(flush_ready),
      .busy_vec(busy_vec), .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_err_code(rsp_err_code),
      .err_log(err_log), .irq_fatal(irq_fatal), .irq_nonfatal(irq_nonfatal),
      .flush_valid(flush_valid), .flush_tag(flush_tag), .flush_kind(flush_kind)
   );

   typedef struct packed {
      logic          is_rsp;
      logic [TW-1:0] tag;
      logic [1:0]    kind;     // request class, or bit0 = read response
      logic [CW-1:0] cnt;
      logic          exp_done;
      logic          exp_err;
      logic [1:0]    exp_code;
      logic          exp_busy;
   } vec_t;

   localparam int NV = 17;
   localparam vec_t VEC [NV] = '{
      '{1'b0, 5'd3,  2'b00, 4'd5,  1'b0, 1'b0, 2'd0, 1'b1},  // R1 sized read
      '{1'b0, 5'd7,  2'b10, 4'd0,  1'b0, 1'b0, 2'd0, 1'b1},  // R1 np write
      '{1'b0, 5'd9,  2'b01, 4'd1,  1'b0, 1'b0, 2'd0, 1'b1},  // R1 atomic
      '{1'b1, 5'd3,  2'b01, 4'd5,  1'b1, 1'b0, 2'd0, 1'b0},  // R2 good read
      '{1'b1, 5'd3,  2'b01, 4'd5,  1'b0, 1'b1, 2'd0, 1'b0},  // R3 repeat
      '{1'b1, 5'd7,  2'b01, 4'd0,  1'b0, 1'b1, 2'd1, 1'b1},  // R4
      '{1'b1, 5'd7,  2'b00, 4'd9,  1'b1, 1'b0, 2'd0, 1'b0},  // R2 done, count ignored
      '{1'b1, 5'd9,  2'b00, 4'd1,  1'b0, 1'b1, 2'd2, 1'b1},  // R5 atomic
      '{1'b1, 5'd9,  2'b01, 4'd2,  1'b0, 1'b1, 2'd3, 1'b1},  // R6
      '{1'b1, 5'd9,  2'b01, 4'd1,  1'b1, 1'b0, 2'd0, 1'b0},  // R2 atomic
      '{1'b0, 5'd0,  2'b00, 4'd15, 1'b0, 1'b0, 2'd0, 1'b1},  // R1 low tag
      '{1'b1, 5'd0,  2'b01, 4'd14, 1'b0, 1'b1, 2'd3, 1'b1},  // R6 off by one
      '{1'b1, 5'd0,  2'b01, 4'd15, 1'b1, 1'b0, 2'd0, 1'b0},  // R2
      '{1'b0, 5'd31, 2'b00, 4'd0,  1'b0, 1'b0, 2'd0, 1'b1},  // R1 high tag
      '{1'b1, 5'd31, 2'b00, 4'd0,  1'b0, 1'b1, 2'd2, 1'b1},  // R5 sized read
      '{1'b0, 5'd5,  2'b11, 4'd3,  1'b0, 1'b0, 2'd0, 1'b1},  // R1 class 11
      '{1'b1, 5'd5,  2'b00, 4'd0,  1'b1, 1'b0, 2'd0, 1'b0}   // R2 class 11
   };

   task automatic chk(input string rq, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
      end
   endtask

   task automatic idle();
      req_valid = 1'b0; rsp_valid = 1'b0; chain_fail = 1'b0;
   endtask

   task automatic do_req(input int tag, input int kind, input int cnt);
      @(negedge clk);
      req_valid = 1'b1; req_tag = TW'(tag); req_kind = 2'(kind); req_count = CW'(cnt);
      @(posedge clk);
      @(negedge clk);
      idle();
   endtask

   task automatic do_rsp(input int tag, input bit rd, input int cnt);
      @(negedge clk);
      rsp_valid = 1'b1; rsp_tag = TW'(tag); rsp_is_read = rd; rsp_count = CW'(cnt);
      @(posedge clk);
      @(negedge clk);
      idle();
   endtask

   initial begin
      #(200000 * 10);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

   initial begin
      rst_n = 1'b0; idle();
      req_tag = '0; req_kind = '0; req_count = '0;
      rsp_tag = '0; rsp_is_read = 1'b0; rsp_count = '0;
      cfg_fatal_en = 1'b1; cfg_nonfatal_en = 1'b0; flush_ready = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R9 reset state
      chk("R9", "busy_vec", int'(busy_vec != '0), 0);
      chk("R9", "outputs", int'({rsp_done, rsp_err, err_log, irq_fatal, irq_nonfatal, flush_valid}), 0);

      // Vector table
      for (int i = 0; i < NV; i++) begin
         if (VEC[i].is_rsp) begin
            do_rsp(int'(VEC[i].tag), VEC[i].kind[0], int'(VEC[i].cnt));
         end else begin
            do_req(int'(VEC[i].tag), int'(VEC[i].kind), int'(VEC[i].cnt));
         end
         // after do_*: we are at the negedge following the capturing edge
         if (VEC[i].is_rsp) begin
            chk("R2", $sformatf("vec%0d rsp_done", i), int'(rsp_done), int'(VEC[i].exp_done));
            chk("R3", $sformatf("vec%0d rsp_err", i), int'(rsp_err), int'(VEC[i].exp_err));
            if (VEC[i].exp_err)
               chk("R6", $sformatf("vec%0d rsp_err_code", i), int'(rsp_err_code), int'(VEC[i].exp_code));
            chk("R7", $sformatf("vec%0d irq_fatal", i), int'(irq_fatal), int'(VEC[i].exp_err));
            chk("R7", $sformatf("vec%0d irq_nonfatal", i), int'(irq_nonfatal), 0);
         end
         chk("R1", $sformatf("vec%0d busy", i), int'(busy_vec[VEC[i].tag]), int'(VEC[i].exp_busy));
      end

      // R7 sticky log, swapped interrupt mapping
      chk("R7", "err_log sticky", int'(err_log), 1);
      cfg_fatal_en = 1'b0; cfg_nonfatal_en = 1'b1;
      do_rsp(12, 1'b0, 0);
      chk("R3", "unknown tag err", int'(rsp_err), 1);
      chk("R7", "irq_nonfatal", int'(irq_nonfatal), 1);
      chk("R7", "irq_fatal masked", int'(irq_fatal), 0);
      @(negedge clk);
      chk("R7", "err_log held", int'(err_log), 1);

      // R1 request to busy tag ignored
      do_req(4, 0, 2);
      do_req(4, 2, 0);
      do_rsp(4, 1'b1, 2);
      chk("R1", "busy tag kept original entry", int'(rsp_done), 1);

      // R8 flush (tag 31 still busy from the table)
      do_req(20, 2, 0);
      do_req(2, 0, 6);
      do_req(10, 1, 3);
      @(negedge clk);
      chain_fail = 1'b1; flush_ready = 1'b0;
      req_valid = 1'b1; req_tag = TW'(25); req_kind = 2'b00; req_count = '0;
      @(posedge clk);
      @(negedge clk);
      idle();
      chk("R8", "flush_valid first", int'(flush_valid), 1);
      chk("R8", "flush_tag lowest", int'(flush_tag), 2);
      chk("R8", "flush_kind", int'(flush_kind), 0);
      rsp_valid = 1'b1; rsp_tag = TW'(10); rsp_is_read = 1'b1; rsp_count = CW'(3);
      @(posedge clk);
      @(negedge clk);
      idle();
      chk("R8", "tag held under backpressure", int'(flush_tag), 2);
      chk("R8", "response ignored in flush", int'(rsp_done | rsp_err), 0);
      chk("R8", "chain-fail cycle request ignored", int'(busy_vec[25]), 0);
      flush_ready = 1'b1;
      @(posedge clk);
      @(negedge clk);
      chk("R8", "second tag", int'(flush_tag), 10);
      chk("R8", "second kind", int'(flush_kind), 1);
      @(posedge clk);
      @(negedge clk);
      chk("R8", "third tag", int'(flush_tag), 20);
      chk("R8", "third kind", int'(flush_kind), 2);
      @(posedge clk);
      @(negedge clk);
      chk("R8", "fourth tag", int'(flush_tag), 31);
      @(posedge clk);
      @(negedge clk);
      chk("R8", "flush over", int'(flush_valid), 0);
      chk("R8", "table empty", int'(busy_vec != '0), 0);
      flush_ready = 1'b0;
      do_req(2, 0, 1);
      chk("R1", "alloc after flush", int'(busy_vec[2]), 1);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

endmodule